// File: doc/BRIEF.md
# Dual-Plane DMA Channel Engine

A single memory-to-memory DMA channel. Software programs a source address, a destination address and a unit count into one of two parameter planes through a word-addressed register port, then writes a command word. The channel copies data one unit at a time. Each unit is a read beat followed by a write beat on a simple request/acknowledge memory master. The unit is 1, 2 or 4 bytes, and both addresses advance by the unit size after each unit. The count of the active plane falls by one per unit, so software can read back how much is left at any time.

In alternating mode the two planes work as a double buffer. While the channel drains one plane, software fills the other and posts a continuation command. When the running plane empties, the channel pulses `done` and moves straight to the other plane without going idle. A forced stop ends the run at the next beat boundary and leaves the counts readable. One register block covers 0x40 bytes, so a channel array places further channels at a 0x40 stride.

The controller is a state machine with six states:
- ST_IDLE: the channel waits for a command.
- ST_CHECK: the active count is examined.
- ST_READ and ST_WRITE: the two beats of a unit.
- ST_STEP: the active plane's addresses and count are updated.
- ST_DONE: the one-cycle completion state.

The transitions are:
- IDLE→CHECK: on a valid start.
- CHECK→READ: when the count is non-zero.
- CHECK→DONE: when the count is zero.
- READ→WRITE: on the read acknowledge.
- READ→IDLE: on the read acknowledge when a stop is pending.
- WRITE→STEP: on the write acknowledge.
- STEP→READ: when units remain.
- STEP→DONE: after the last unit.
- STEP→IDLE: when a stop is pending.
- DONE→CHECK: chaining to the other plane.
- DONE→IDLE: in every other case.
- CHECK→IDLE: on a pending stop.

Top module: `dual_plane_dma`

## Requirements
- R1: After reset the channel is idle, every plane register and the status word (0x24) read 0, and `mem_req` and `done` are low.
- R2: Plane 0 source, destination and count sit at 0x00, 0x04 and 0x08, and plane 1 uses 0x0C, 0x10 and 0x14. Control sits at 0x18. All of these read back what was written while the channel is idle.
- R3: Control bits [1:0] select the unit size: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes. A started transfer copies `count` units, each a read at the source followed by a write of that data at the destination. Both addresses grow by the unit size per unit and read back advanced afterwards.
- R4: Writing 1 to bit 0 of the command word (0x1C) starts the channel. Status bit 0 reads 1 while the channel is active. The active plane's count decrements by one per completed unit and can be read mid-transfer.
- R5: When the active count reaches zero, `done` is high for exactly one cycle. Busy then clears unless a chained plane follows.
- R6: Control bits 2 and 3 both set select alternating mode, and both clear select single mode. In alternating mode the first start after a control write uses plane 0. A start with command bit 1 set, issued while idle, uses the plane opposite to the last one. Status bit 1 shows the active plane.
- R7: In alternating mode, a command with bits 0 and 1 set, written while busy, is held. When the active plane empties, `done` pulses and the channel continues on the other plane without going idle.
- R8: A start-with-continuation command written in the same cycle as the `done` pulse is honoured as a chain.
- R9: Command bit 2 (end of queue), written while busy, cancels a held continuation.
- R10: A start issued with control bits 2 and 3 unequal is ignored: the channel stays idle and issues no memory access.
- R11: Writing 1 to bit 0 of the stop word (0x20) during a transfer halts the channel at the next beat boundary without a `done` pulse. The remaining count equals the original count minus the units whose write completed.
- R12: A count write larger than 16 MiB divided by the current unit size is clamped to that limit.
- R13: A start with a zero count pulses `done` without any memory access.
- R14: `mem_req` stays high, with `mem_addr` and `mem_we` stable, from the cycle it rises until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset within the channel block |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat byte address |
| mem_size | output | 2 | log2 of the unit size in bytes |
| mem_wdata | output | 32 | Write beat data |
| mem_rdata | input | 32 | Read beat data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat acknowledge |
| busy | output | 1 | Channel active |
| done | output | 1 | One-cycle completion pulse |

## Verification
The delicate collision is a continuation command that arrives in the very cycle the controller sits in ST_DONE. In that cycle the held-continuation flag is being cleared while the chaining choice is being made. The bench watches for `done` at a falling edge and drives the start-with-continuation write into that same cycle. It then judges the outcome from the destination memory of plane 1, from a second `done` pulse and from the plane bit in the status word. A second pairing is a stop landing mid-beat. Its result is judged by matching the remaining count against the number of write beats the memory model actually served.

// File: rtl/dpdma_pkg.sv
package dpdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ,
        ST_WRITE,
        ST_STEP,
        ST_DONE
    } dma_state_e;

    // Word indices inside one channel block
    localparam int PLANE_WORDS = 3;
    localparam int WI_CTRL     = 6;
    localparam int WI_CMD      = 7;
    localparam int WI_STOP     = 8;
    localparam int WI_STAT     = 9;

    // Command word bit positions
    localparam int CB_GO   = 0;
    localparam int CB_NEXT = 1;
    localparam int CB_LAST = 2;

endpackage

// File: rtl/dpdma_regs.sv
module dpdma_regs
    import dpdma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 25,
    parameter int MAX_BYTES = 2**24,
    parameter int REG_AW    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              step,
    input  logic              plane_set_en,
    input  logic              plane_set_val,
    output logic              plane_q,
    output logic [ADDR_W-1:0] act_src,
    output logic [ADDR_W-1:0] act_dst,
    output logic [CNT_W-1:0]  act_cnt,
    output logic [1:0]        unit_shift,
    output logic              mode_valid,
    output logic              dbl_mode,
    output logic              start_cmd,
    output logic              next_cmd,
    output logic              last_cmd,
    output logic              stop_cmd
);

    localparam int          IDX_W = REG_AW - 2;
    localparam logic [31:0] MAX_B = 32'(MAX_BYTES);

    logic [3:0]       ctrl_q;
    logic             word_ok;
    logic             wr_en;
    logic [IDX_W-1:0] widx;
    logic [31:0]      lim;
    logic [CNT_W-1:0] cnt_wval;
    logic [ADDR_W-1:0] step_inc;
    logic             ctrl_wr;

    assign word_ok    = (reg_addr[1:0] == 2'b00);
    assign wr_en      = reg_wr && word_ok;
    assign widx       = reg_addr[REG_AW-1:2];
    assign unit_shift = (ctrl_q[1:0] == 2'd3) ? 2'd2 : ctrl_q[1:0];
    assign lim        = MAX_B >> unit_shift;
    assign cnt_wval   = (reg_wdata > lim) ? CNT_W'(lim) : CNT_W'(reg_wdata);
    assign step_inc   = ADDR_W'(1) << unit_shift;
    assign mode_valid = (ctrl_q[2] == ctrl_q[3]);
    assign dbl_mode   = ctrl_q[2] & ctrl_q[3];
    assign ctrl_wr    = wr_en && (widx == IDX_W'(WI_CTRL)) && !busy;

    assign start_cmd = wr_en && (widx == IDX_W'(WI_CMD)) && reg_wdata[CB_GO];
    assign next_cmd  = wr_en && (widx == IDX_W'(WI_CMD)) && reg_wdata[CB_NEXT];
    assign last_cmd  = wr_en && (widx == IDX_W'(WI_CMD)) && reg_wdata[CB_LAST];
    assign stop_cmd  = wr_en && (widx == IDX_W'(WI_STOP)) && reg_wdata[0];

    // Two parameter planes; the active one is stepped by the engine and
    // protected from host writes while the channel runs.
    for (genvar p = 0; p < 2; p++) begin : g_plane
        localparam logic [IDX_W-1:0] BASE = IDX_W'(p * PLANE_WORDS);
        logic [ADDR_W-1:0] src_q;
        logic [ADDR_W-1:0] dst_q;
        logic [CNT_W-1:0]  cnt_q;
        logic              is_act;
        logic              host_ok;

        assign is_act  = (plane_q == 1'(p));
        assign host_ok = wr_en && !(busy && is_act);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                src_q <= '0;
                dst_q <= '0;
                cnt_q <= '0;
            end else if (step && is_act) begin
                src_q <= src_q + step_inc;
                dst_q <= dst_q + step_inc;
                cnt_q <= cnt_q - CNT_W'(1);
            end else if (host_ok) begin
                if (widx == BASE)              src_q <= ADDR_W'(reg_wdata);
                if (widx == BASE + IDX_W'(1))  dst_q <= ADDR_W'(reg_wdata);
                if (widx == BASE + IDX_W'(2))  cnt_q <= cnt_wval;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            plane_q <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= reg_wdata[3:0];
            if (plane_set_en)  plane_q <= plane_set_val;
            else if (ctrl_wr)  plane_q <= 1'b0;
        end
    end

    assign act_src = plane_q ? g_plane[1].src_q : g_plane[0].src_q;
    assign act_dst = plane_q ? g_plane[1].dst_q : g_plane[0].dst_q;
    assign act_cnt = plane_q ? g_plane[1].cnt_q : g_plane[0].cnt_q;

    always_comb begin
        reg_rdata = '0;
        if (word_ok) begin
            case (widx)
                IDX_W'(0):       reg_rdata = 32'(g_plane[0].src_q);
                IDX_W'(1):       reg_rdata = 32'(g_plane[0].dst_q);
                IDX_W'(2):       reg_rdata = 32'(g_plane[0].cnt_q);
                IDX_W'(3):       reg_rdata = 32'(g_plane[1].src_q);
                IDX_W'(4):       reg_rdata = 32'(g_plane[1].dst_q);
                IDX_W'(5):       reg_rdata = 32'(g_plane[1].cnt_q);
                IDX_W'(WI_CTRL): reg_rdata = 32'(ctrl_q);
                IDX_W'(WI_STAT): reg_rdata = {30'd0, plane_q, busy};
                default:         reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dpdma_engine.sv
module dpdma_engine
    import dpdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cmd,
    input  logic              next_cmd,
    input  logic              last_cmd,
    input  logic              stop_cmd,
    input  logic              mode_valid,
    input  logic              dbl_mode,
    input  logic [1:0]        unit_shift,
    input  logic              plane_q,
    input  logic [ADDR_W-1:0] act_src,
    input  logic [ADDR_W-1:0] act_dst,
    input  logic [CNT_W-1:0]  act_cnt,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic              step,
    output logic              plane_set_en,
    output logic              plane_set_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata
);

    dma_state_e        state_q, state_d;
    logic              pending_q;
    logic              stop_q;
    logic [DATA_W-1:0] data_q;
    logic              chain;

    // Continuation is taken from the held flag or from a command landing now.
    assign chain = dbl_mode && !stop_q &&
                   ((pending_q && !last_cmd) || (start_cmd && next_cmd));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_cmd && mode_valid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (stop_q)                   state_d = ST_IDLE;
                else if (act_cnt == '0)       state_d = ST_DONE;
                else                          state_d = ST_READ;
            end
            ST_READ:  if (mem_ack) state_d = stop_q ? ST_IDLE : ST_WRITE;
            ST_WRITE: if (mem_ack) state_d = ST_STEP;
            ST_STEP: begin
                if (stop_q)                   state_d = ST_IDLE;
                else if (act_cnt == CNT_W'(1)) state_d = ST_DONE;
                else                          state_d = ST_READ;
            end
            ST_DONE:  state_d = chain ? ST_CHECK : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Side registers: held continuation, stop request, beat data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            stop_q    <= 1'b0;
            data_q    <= '0;
        end else begin
            if (state_q == ST_IDLE || state_q == ST_DONE) pending_q <= 1'b0;
            else if (last_cmd)                            pending_q <= 1'b0;
            else if (start_cmd && next_cmd && dbl_mode)   pending_q <= 1'b1;

            if (state_q == ST_IDLE) stop_q <= 1'b0;
            else if (stop_cmd)      stop_q <= 1'b1;

            if (state_q == ST_READ && mem_ack) data_q <= mem_rdata;
        end
    end

    // Outputs
    always_comb begin
        busy          = (state_q != ST_IDLE);
        done          = (state_q == ST_DONE);
        step          = (state_q == ST_STEP);
        mem_req       = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we        = (state_q == ST_WRITE);
        mem_addr      = (state_q == ST_WRITE) ? act_dst : act_src;
        mem_size      = unit_shift;
        mem_wdata     = data_q;
        plane_set_en  = 1'b0;
        plane_set_val = 1'b0;
        if (state_q == ST_IDLE && start_cmd && mode_valid) begin
            plane_set_en  = 1'b1;
            plane_set_val = (dbl_mode && next_cmd) ? ~plane_q : 1'b0;
        end else if (state_q == ST_DONE && chain) begin
            plane_set_en  = 1'b1;
            plane_set_val = ~plane_q;
        end
    end

endmodule

// File: rtl/dual_plane_dma.sv
module dual_plane_dma
    import dpdma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 25,
    parameter int MAX_BYTES = 2**24,
    parameter int REG_AW    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done
);

    logic              step_w;
    logic              plane_set_en_w;
    logic              plane_set_val_w;
    logic              plane_w;
    logic [ADDR_W-1:0] act_src_w;
    logic [ADDR_W-1:0] act_dst_w;
    logic [CNT_W-1:0]  act_cnt_w;
    logic [1:0]        unit_shift_w;
    logic              mode_valid_w;
    logic              dbl_mode_w;
    logic              start_w;
    logic              next_w;
    logic              last_w;
    logic              stop_w;

    dpdma_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES), .REG_AW(REG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .step(step_w),
        .plane_set_en(plane_set_en_w), .plane_set_val(plane_set_val_w),
        .plane_q(plane_w), .act_src(act_src_w), .act_dst(act_dst_w), .act_cnt(act_cnt_w),
        .unit_shift(unit_shift_w), .mode_valid(mode_valid_w), .dbl_mode(dbl_mode_w),
        .start_cmd(start_w), .next_cmd(next_w), .last_cmd(last_w), .stop_cmd(stop_w)
    );

    dpdma_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start_cmd(start_w), .next_cmd(next_w), .last_cmd(last_w), .stop_cmd(stop_w),
        .mode_valid(mode_valid_w), .dbl_mode(dbl_mode_w), .unit_shift(unit_shift_w),
        .plane_q(plane_w), .act_src(act_src_w), .act_dst(act_dst_w), .act_cnt(act_cnt_w),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .done(done), .step(step_w),
        .plane_set_en(plane_set_en_w), .plane_set_val(plane_set_val_w),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata)
    );

endmodule

// File: rtl/dpdma_checker.sv
module dpdma_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              step,
    input logic [CNT_W-1:0]  act_cnt
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (act_cnt == '0)); // R5

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (act_cnt == $past(act_cnt) - CNT_W'(1))); // R4

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R14

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R1

endmodule

bind dual_plane_dma dpdma_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dpdma_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .step(step_w), .act_cnt(act_cnt_w)
);

// File: tb/dual_plane_dma_bench.sv
`timescale 1ns/1ps
module dual_plane_dma_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack, busy, done;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;

    int checks = 0;
    int fails  = 0;
    int rd_cnt = 0, wr_cnt = 0, hs_err = 0, done_cnt = 0;

    logic [31:0] mem [0:4095];
    logic        pend_q;
    logic [31:0] paddr_q;

    always #10 clk = ~clk;

    dual_plane_dma u_dual_plane_dma (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .done(done)
    );

    function automatic logic [31:0] pre(input int a);
        return 32'hA500_0000 | 32'(a);
    endfunction

    // Memory model: one-cycle acknowledge, byte-addressed word store.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            pend_q    <= 1'b0;
            paddr_q   <= '0;
            for (int i = 0; i < 4096; i++) mem[i] <= pre(i);
        end else begin
            pend_q  <= mem_req && !mem_ack;
            paddr_q <= mem_addr;
            if (pend_q && (!mem_req || mem_addr != paddr_q)) hs_err <= hs_err + 1;
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr[11:0]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rdata <= mem[mem_addr[11:0]];
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    always @(negedge clk) if (rst_n && done) done_cnt++;

    task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        check(tag, act === exp, act, exp);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(6'h24, s);
            if (s[0] == 1'b0) return;
        end
        check(tag, 1'b0, 32'd1, 32'd0);
    endtask

    task automatic plane(input int p, input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
        wr(6'(p * 12), s);
        wr(6'(p * 12 + 4), d);
        wr(6'(p * 12 + 8), n);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(6'h24, v); check_eq("R1 status", v, 32'd0);
        rd(6'h08, v); check_eq("R1 count0", v, 32'd0);
        rd(6'h10, v); check_eq("R1 dest1", v, 32'd0);
        check_eq("R1 mem_req", 32'(mem_req), 32'd0);
        check_eq("R1 done", 32'(done), 32'd0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        wr(6'h18, 32'h0);
        plane(0, 32'h1111_0010, 32'h2222_0020, 32'h0000_0123);
        plane(1, 32'h3333_0030, 32'h4444_0040, 32'h0000_0456);
        wr(6'h18, 32'hE);
        rd(6'h00, v); check_eq("R2 src0", v, 32'h1111_0010);
        rd(6'h04, v); check_eq("R2 dst0", v, 32'h2222_0020);
        rd(6'h08, v); check_eq("R2 cnt0", v, 32'h0000_0123);
        rd(6'h0C, v); check_eq("R2 src1", v, 32'h3333_0030);
        rd(6'h10, v); check_eq("R2 dst1", v, 32'h4444_0040);
        rd(6'h14, v); check_eq("R2 cnt1", v, 32'h0000_0456);
        rd(6'h18, v); check_eq("R2 ctrl", v, 32'hE);
    endtask

    task automatic t_single_word();
        logic [31:0] v;
        int d0;
        d0 = done_cnt;
        wr(6'h18, 32'h2);
        plane(0, 32'h100, 32'h200, 32'd4);
        wr(6'h1C, 32'h1);
        repeat (8) @(negedge clk);
        rd(6'h24, v); check_eq("R4 busy mid", v & 32'h1, 32'h1);
        rd(6'h08, v); check("R4 count mid", v > 0 && v < 4, v, 32'd2);
        wait_idle("R5 idle");
        for (int i = 0; i < 4; i++)
            check_eq("R3 word copy", mem[12'h200 + 4 * i], pre(32'h100 + 4 * i));
        rd(6'h08, v); check_eq("R4 count end", v, 32'd0);
        rd(6'h00, v); check_eq("R3 src advanced", v, 32'h110);
        check_eq("R5 one done", 32'(done_cnt - d0), 32'd1);
        rd(6'h24, v); check_eq("R5 busy clear", v, 32'd0);
    endtask

    task automatic t_single_byte();
        logic [31:0] v;
        wr(6'h18, 32'h0);
        plane(0, 32'h300, 32'h340, 32'd3);
        wr(6'h1C, 32'h1);
        wait_idle("R3 idle");
        check_eq("R3 byte copy", mem[12'h341], pre(32'h301));
        check_eq("R3 byte copy last", mem[12'h342], pre(32'h302));
        rd(6'h00, v); check_eq("R3 byte src", v, 32'h303);
        rd(6'h04, v); check_eq("R3 byte dst", v, 32'h343);
    endtask

    task automatic t_invalid();
        logic [31:0] v;
        int w0, d0;
        w0 = wr_cnt; d0 = done_cnt;
        wr(6'h18, 32'h6);
        plane(0, 32'h100, 32'h380, 32'd2);
        wr(6'h1C, 32'h1);
        repeat (5) @(negedge clk);
        rd(6'h24, v); check_eq("R10 stays idle", v, 32'd0);
        check_eq("R10 no access", 32'(wr_cnt - w0), 32'd0);
        check_eq("R10 no done", 32'(done_cnt - d0), 32'd0);
    endtask

    task automatic t_double();
        logic [31:0] v;
        int d0;
        d0 = done_cnt;
        wr(6'h18, 32'hE);
        plane(0, 32'h100, 32'h400, 32'd2);
        plane(1, 32'h120, 32'h480, 32'd2);
        wr(6'h1C, 32'h1);
        wr(6'h1C, 32'h3);
        wait_idle("R7 idle");
        check_eq("R6 first plane0", mem[12'h404], pre(32'h104));
        check_eq("R7 chained plane1", mem[12'h484], pre(32'h124));
        check_eq("R7 two dones", 32'(done_cnt - d0), 32'd2);
        rd(6'h24, v); check_eq("R7 status plane1", v, 32'd2);
        plane(0, 32'h100, 32'h500, 32'd1);
        wr(6'h1C, 32'h3);
        wait_idle("R6 idle");
        check_eq("R6 next from idle", mem[12'h500], pre(32'h100));
        rd(6'h24, v); check_eq("R6 status plane0", v, 32'd0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        int d0;
        bit seen;
        d0 = done_cnt;
        seen = 1'b0;
        wr(6'h18, 32'hE);
        plane(0, 32'h100, 32'h600, 32'd1);
        plane(1, 32'h104, 32'h680, 32'd1);
        wr(6'h1C, 32'h1);
        for (int i = 0; i < 100 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        reg_addr = 6'h1C; reg_wdata = 32'h3; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        wait_idle("R8 idle");
        check_eq("R8 done seen", 32'(seen), 32'd1);
        check_eq("R8 plane1 copy", mem[12'h680], pre(32'h104));
        check_eq("R8 two dones", 32'(done_cnt - d0), 32'd2);
        rd(6'h24, v); check_eq("R8 status plane1", v, 32'd2);
    endtask

    task automatic t_eoq();
        logic [31:0] v;
        int d0;
        d0 = done_cnt;
        wr(6'h18, 32'hE);
        plane(0, 32'h100, 32'h700, 32'd2);
        plane(1, 32'h120, 32'h780, 32'd1);
        wr(6'h1C, 32'h1);
        wr(6'h1C, 32'h3);
        wr(6'h1C, 32'h4);
        wait_idle("R9 idle");
        check_eq("R9 plane1 untouched", mem[12'h780], pre(32'h780));
        check_eq("R9 one done", 32'(done_cnt - d0), 32'd1);
        rd(6'h24, v); check_eq("R9 status plane0", v, 32'd0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        int w0, d0, units;
        w0 = wr_cnt; d0 = done_cnt;
        wr(6'h18, 32'h2);
        plane(0, 32'h100, 32'h800, 32'd20);
        wr(6'h1C, 32'h1);
        repeat (12) @(negedge clk);
        wr(6'h20, 32'h1);
        wait_idle("R11 idle");
        units = wr_cnt - w0;
        rd(6'h08, v);
        check("R11 partial", units > 0 && units < 20, 32'(units), 32'd10);
        check_eq("R11 remaining", v, 32'(20 - units));
        check_eq("R11 no done", 32'(done_cnt - d0), 32'd0);
    endtask

    task automatic t_clamp();
        logic [31:0] v;
        wr(6'h18, 32'h2);
        wr(6'h08, 32'h0200_0000);
        rd(6'h08, v); check_eq("R12 clamp 4B", v, 32'h0040_0000);
        wr(6'h18, 32'h0);
        wr(6'h14, 32'h0100_0001);
        rd(6'h14, v); check_eq("R12 clamp 1B", v, 32'h0100_0000);
        wr(6'h14, 32'h00FF_FFFF);
        rd(6'h14, v); check_eq("R12 below limit", v, 32'h00FF_FFFF);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        int r0, d0;
        r0 = rd_cnt; d0 = done_cnt;
        wr(6'h18, 32'h2);
        wr(6'h08, 32'h0);
        wr(6'h1C, 32'h1);
        wait_idle("R13 idle");
        check_eq("R13 done", 32'(done_cnt - d0), 32'd1);
        check_eq("R13 no read", 32'(rd_cnt - r0), 32'd0);
        rd(6'h24, v); check_eq("R13 status", v, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_single_word();
        t_single_byte();
        t_invalid();
        t_double();
        t_same_cycle();
        t_eoq();
        t_stop();
        t_clamp();
        t_zero();
        check_eq("R14 handshake held", 32'(hs_err), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule